// File: doc/BRIEF.md
# Frame-Buffer DRAM Read Capture

This block sits on the read-data side of a small frame-buffer memory controller and turns words returning from an external DRAM into a clean stream in the dot-clock domain. A five-bit configuration register picks the memory type (EDO DRAM or SDRAM). It also picks how returning data is sampled: the dot-clock edge used and whether one extra cycle of latch delay is added. Both sampling choices matter only for EDO parts. SDRAM data is always taken on the rising edge with no added delay.

The same register sets the memory-clock rate. The memory clock either runs at the dot-clock rate or, for high-resolution panels, at two-thirds of it. That rate is given as a clock enable that the rest of the controller uses to qualify its memory-clock edges. A polarity output tells the clock pad logic whether the SDRAM clock is to be inverted. The dot clock may run up to 65 MHz and has no lower limit. Command sequencing and refresh live elsewhere. Here a word is offered by raising `mem_arrive` for one dot-clock cycle while `mem_dq` carries the data.

Top module: `dram_rdcap`

## Requirements
- R1: After reset the configuration is all zeros (EDO, rising-edge capture, no late latch, full rate), `cap_valid` is 0, `mclk_en` is 1 and `mclk_inv` is 0.
- R2: In EDO mode with rising-edge capture and no late latch, a word offered during cycle n is taken at the rising edge that ends cycle n. `cap_valid` is then 1 for exactly cycle n+1, and `cap_data` equals the `mem_dq` value at that rising edge.
- R3: In EDO mode with falling-edge capture, `cap_data` carries the `mem_dq` value present at the falling clock edge in the middle of the offering cycle. The latency is the same as in R2.
- R4: In EDO mode with the late latch on, every captured word appears one cycle later than it would without it, and the data choice is unchanged.
- R5: Configuration bits, written through `cfg_we`/`cfg_wdata` and active from the cycle after the write edge, are: bit 0 memory type (0 EDO, 1 SDRAM), bit 1 SDRAM clock polarity (0 inverted, 1 true), bit 2 late latch (1 on), bit 3 capture edge (0 rising, 1 falling), bit 4 clock rate (0 full, 1 two-thirds).
- R6: In SDRAM mode bits 2 and 3 have no effect: capture is on the rising edge with the R2 latency.
- R7: With bit 4 at 0, `mclk_en` is 1 in every cycle.
- R8: After bit 4 is written from 0 to 1, `mclk_en` follows the repeating pattern 1,1,0 starting in the first cycle the new value is active.
- R9: A word offered in a cycle where `mclk_en` is 0 is dropped and produces no `cap_valid`.
- R10: `mclk_inv` is 1 exactly when SDRAM mode is selected and bit 1 is 0.
- R11: Each accepted word gives exactly one `cap_valid` cycle. Words offered in consecutive enabled cycles come out in consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write value |
| mem_dq | input | DATA_W | Raw data returning from the DRAM |
| mem_arrive | input | 1 | Marks a cycle in which a word is offered |
| cap_data | output | DATA_W | Captured word |
| cap_valid | output | 1 | One-cycle strobe per captured word |
| mclk_en | output | 1 | Memory-clock enable in the dot-clock domain |
| mclk_inv | output | 1 | Requests an inverted SDRAM clock |

## Verification
The bench builds the block with a 12-bit data path and the default rate period of 3. This keeps the two-thirds pattern short enough that every phase of it meets every one of the 32 configuration values within a few dozen cycles. Inside each configuration, `mem_dq` is changed between the falling and the next rising edge. Each capture edge therefore sees a different value, and a swapped edge choice shows up in the data. Random offers across the 1,1,0 pattern reach dropped words, back-to-back words and late-latch overlap.

// File: rtl/mcap_pkg.sv
package mcap_pkg;

  // Configuration layout, MSB first: bit4 rate, bit3 edge, bit2 late, bit1 clk polarity, bit0 type
  typedef struct packed {
    logic slow_rate;
    logic fall_edge;
    logic late;
    logic clk_true;
    logic sdram;
  } mcap_cfg_t;

  localparam int unsigned CFG_W = $bits(mcap_cfg_t);

  // Edge choice is honoured only for EDO parts
  function automatic logic use_fall(input mcap_cfg_t c);
    return !c.sdram && c.fall_edge;
  endfunction

  // Late latch is honoured only for EDO parts
  function automatic logic use_late(input mcap_cfg_t c);
    return !c.sdram && c.late;
  endfunction

  // Cycles from the taking edge to the strobe
  function automatic int unsigned word_latency(input mcap_cfg_t c);
    return use_late(c) ? 2 : 1;
  endfunction

  function automatic logic want_inv(input mcap_cfg_t c);
    return c.sdram && !c.clk_true;
  endfunction

endpackage

// File: rtl/mcap_cfg_reg.sv
module mcap_cfg_reg
  import mcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_val,
  output mcap_cfg_t        cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= mcap_cfg_t'(wr_val);
  end

endmodule

// File: rtl/mcap_clk_en.sv
module mcap_clk_en #(
  parameter int unsigned PERIOD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic en
);

  localparam int unsigned CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase_q;
  logic          gap_slot;

  assign gap_slot = (phase_q == LAST);
  assign en       = !slow || !gap_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (!slow)    phase_q <= '0;
    else if (gap_slot) phase_q <= '0;
    else               phase_q <= phase_q + 1'b1;
  end

  // R8: in a steady reduced rate every gap follows two enabled cycles
  assert_gap_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && $past(slow) && $past(slow, 2) && !en) |-> ($past(en) && $past(en, 2)));

  // R8: never two gaps in a row
  assert_single_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && $past(slow) && $past(!en)) |-> en);

endmodule

// File: rtl/mcap_capture.sv
module mcap_capture
  import mcap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mcap_cfg_t         cfg,
  input  logic [DATA_W-1:0] raw_dq,
  input  logic              take,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  logic [DATA_W-1:0] fall_q;
  logic [DATA_W-1:0] s1_d, s2_d;
  logic              s1_v, s2_v;
  logic              pick_fall, pick_late;

  assign pick_fall = use_fall(cfg);
  assign pick_late = use_late(cfg);

  // Mid-cycle sample used for falling-edge capture
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= raw_dq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_d <= '0;
      s2_v <= 1'b0;
      s2_d <= '0;
    end else begin
      s1_v <= take;
      s1_d <= pick_fall ? fall_q : raw_dq;
      s2_v <= s1_v;
      s2_d <= s1_d;
    end
  end

  assign out_valid = pick_late ? s2_v : s1_v;
  assign out_data  = pick_late ? s2_d : s1_d;

  // R11: every strobe traces back to an accepted word
  assert_valid_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(take) || $past(take, 2)));

  // R6: SDRAM words always show one cycle after being taken
  assert_sdram_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg.sdram && $past(cfg.sdram)) |-> $past(take));

  // R4: with the late latch held on, words show two cycles after being taken
  assert_late_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pick_late && $past(pick_late) && $past(pick_late, 2)) |-> $past(take, 2));

endmodule

// File: rtl/dram_rdcap.sv
module dram_rdcap
  import mcap_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned RATE_PERIOD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_wdata,
  input  logic [DATA_W-1:0] mem_dq,
  input  logic              mem_arrive,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid,
  output logic              mclk_en,
  output logic              mclk_inv
);

  mcap_cfg_t cfg_q;
  logic      word_take;

  mcap_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_val (cfg_wdata),
    .cfg_q  (cfg_q)
  );

  mcap_clk_en #(.PERIOD(RATE_PERIOD)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .slow  (cfg_q.slow_rate),
    .en    (mclk_en)
  );

  // Words are only real on enabled memory-clock cycles
  assign word_take = mem_arrive && mclk_en;

  mcap_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_q),
    .raw_dq    (mem_dq),
    .take      (word_take),
    .out_data  (cap_data),
    .out_valid (cap_valid)
  );

  assign mclk_inv = want_inv(cfg_q);

  // R10: polarity only changes as a result of a register write
  assert_inv_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_inv) |-> $past(cfg_we));

  // R9: a word offered in a gap never reaches the output stage
  assert_gap_word_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_arrive && !mclk_en && !cfg_q.sdram && !cfg_q.late && !cfg_we) |=> !cap_valid);

endmodule

// File: tb/dram_rdcap_tb_top.sv
module dram_rdcap_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW         = 12;
  localparam int unsigned RP         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_wdata = '0;
  logic [DW-1:0] mem_dq = '0;
  logic          mem_arrive = 1'b0;
  logic [DW-1:0] cap_data;
  logic          cap_valid;
  logic          mclk_en;
  logic          mclk_inv;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_rdcap #(.DATA_W(DW), .RATE_PERIOD(RP)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .mem_dq     (mem_dq),
    .mem_arrive (mem_arrive),
    .cap_data   (cap_data),
    .cap_valid  (cap_valid),
    .mclk_en    (mclk_en),
    .mclk_inv   (mclk_inv)
  );

  // Bench model state
  int            k = 0;
  logic [4:0]    cfg_m = '0;
  logic [4:0]    wd_pend = '0;
  logic          we_pend = 1'b0;
  int            slow_k = 0;
  logic          exp_v [8];
  logic [DW-1:0] exp_d [8];
  string         exp_t [8];

  // Field meanings follow R5: bit0 type, bit1 polarity, bit2 late, bit3 edge, bit4 rate
  function automatic bit m_sdram(input logic [4:0] c); return c[0]; endfunction
  function automatic bit m_fall(input logic [4:0] c); return !c[0] && c[3]; endfunction
  function automatic bit m_late(input logic [4:0] c); return !c[0] && c[2]; endfunction
  function automatic bit m_inv(input logic [4:0] c); return c[0] && !c[1]; endfunction
  function automatic bit m_en(input logic [4:0] c, input int cyc, input int start);
    if (!c[4]) return 1'b1;
    return ((cyc - start) % RP) != (RP - 1);
  endfunction
  function automatic string mode_tag(input logic [4:0] c);
    if (m_sdram(c)) return "R6";
    if (m_late(c))  return "R4";
    if (m_fall(c))  return "R3";
    return "R2";
  endfunction

  task automatic check1(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic check_outputs();
    int s = k % 8;
    check1(exp_t[s], "cap_valid", 32'(cap_valid), 32'(exp_v[s]));
    if (exp_v[s]) check1(exp_t[s], "cap_data", 32'(cap_data), 32'(exp_d[s]));
    exp_v[s] = 1'b0;
    exp_t[s] = "R11";
  endtask

  task automatic step(input logic we, input logic [4:0] wd, input logic arr,
                      input logic [DW-1:0] d1, input logic [DW-1:0] d2);
    logic en_e;
    @(posedge clk);
    k++;
    #2;
    check_outputs();
    if (we_pend) begin
      if (wd_pend[4] && !cfg_m[4]) slow_k = k;
      cfg_m = wd_pend;
    end
    en_e = m_en(cfg_m, k, slow_k);
    check1(cfg_m[4] ? "R8" : "R7", "mclk_en", 32'(mclk_en), 32'(en_e));
    check1("R10", "mclk_inv", 32'(mclk_inv), 32'(m_inv(cfg_m)));
    cfg_we = we;
    cfg_wdata = wd;
    mem_arrive = arr;
    mem_dq = d1;
    we_pend = we;
    wd_pend = wd;
    if (arr && en_e) begin
      int s = (k + 1 + (m_late(cfg_m) ? 1 : 0)) % 8;
      exp_v[s] = 1'b1;
      exp_d[s] = m_fall(cfg_m) ? d1 : d2;
      exp_t[s] = mode_tag(cfg_m);
    end else if (arr) begin
      if (!exp_v[(k + 1) % 8]) exp_t[(k + 1) % 8] = "R9";
      if (!exp_v[(k + 2) % 8]) exp_t[(k + 2) % 8] = "R9";
    end
    @(negedge clk);
    #2;
    mem_dq = d2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'd0, 1'b0, '0, '0);
  endtask

  task automatic write_cfg(input logic [4:0] v);
    step(1'b1, v, 1'b0, '0, '0);
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      exp_v[i] = 1'b0;
      exp_d[i] = '0;
      exp_t[i] = "R11";
    end
    void'($urandom(32'h5EED_2A11));
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    check1("R1", "cap_valid after reset", 32'(cap_valid), 32'd0);
    check1("R1", "mclk_en after reset", 32'(mclk_en), 32'd1);
    check1("R1", "mclk_inv after reset", 32'(mclk_inv), 32'd0);
    idle(2);

    // Directed: default EDO rising, distinct values at each edge (R2)
    step(1'b0, 5'd0, 1'b1, 12'hABC, 12'h123);
    idle(3);
    // Directed: falling edge (R3), then late latch (R4), back-to-back (R11)
    write_cfg(5'b01000);
    step(1'b0, 5'd0, 1'b1, 12'h5A5, 12'hA5A);
    idle(3);
    write_cfg(5'b01100);
    step(1'b0, 5'd0, 1'b1, 12'h111, 12'h222);
    step(1'b0, 5'd0, 1'b1, 12'h333, 12'h444);
    step(1'b0, 5'd0, 1'b1, 12'h555, 12'h666);
    idle(4);
    // Directed: SDRAM ignores edge and late bits (R6), inverted clock (R10)
    write_cfg(5'b01101);
    step(1'b0, 5'd0, 1'b1, 12'h0F0, 12'hF0F);
    idle(3);
    write_cfg(5'b00011);
    idle(2);
    // Directed: reduced rate, offer in every phase incl. the gap (R8, R9)
    write_cfg(5'b00000);
    write_cfg(5'b10000);
    for (int i = 0; i < 6; i++) step(1'b0, 5'd0, 1'b1, DW'(12'h700 + i), DW'(12'h800 + i));
    idle(4);

    // Random sweep over every configuration value
    for (int c = 0; c < 32; c++) begin
      write_cfg(5'(c));
      for (int i = 0; i < 40; i++)
        step(1'b0, 5'd0, 1'($urandom_range(0, 1)), DW'($urandom), DW'($urandom));
      idle(4);
      write_cfg(5'd0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule